// File: doc/BRIEF.md
# Punctured Convolutional Encoder

This block turns the serial, already-scrambled bit stream of one packet into coded bits. Each input bit passes through a rate-1/2 convolutional code with constraint length 7. That produces two candidate output bits, called A and B. A fixed pattern then drops some of them to reach rate 2/3 or rate 3/4. The rate is chosen once per packet, on the bit that carries the start-of-packet marker.

The first 24 bits of every packet are the header, which holds the rate and the length. These bits are always sent at rate 1/2, whatever rate the payload uses. The bits after the header (the service field and the payload) use the selected rate. The puncturing pattern starts from its first position on the first payload bit.

Input and output each use a valid/ready handshake. The output side runs without gaps while the input keeps up. Back-pressure stalls the encoder without losing or repeating any bit, and a puncturing pattern that was interrupted carries on from where it stopped.

Top module: `punct_conv_enc`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1.
- R2: The window is w[6:0] = {new bit, h[5:0]}, where h[5] is the most recent earlier bit of the packet. Then A = XOR of (w & 7'b1011011) (octal 133) and B = XOR of (w & 7'b1111001) (octal 171). The history h is zero for the bit accepted with `inSop` = 1.
- R3: The first 24 input bits of a packet, counting from the `inSop` bit, each produce A and then B, with nothing dropped.
- R4: `rateSel` is sampled only on the bit accepted with `inSop` = 1. The codes are 0 for rate 1/2, 1 for rate 2/3, 2 for rate 3/4, and 3 for rate 1/2. On all other bits `rateSel` has no effect.
- R5: At rate 2/3 the payload bits cycle through two positions. Position 0 emits A then B. Position 1 emits A only.
- R6: At rate 3/4 the payload bits cycle through three positions. Position 0 emits A then B. Position 1 emits A only. Position 2 emits B only.
- R7: The first payload bit of every packet (input bit 25) is at pattern position 0, whatever the previous packet left behind.
- R8: While `outValid` is 1 and `outReady` is 0, `outValid` and `outBit` hold their values in the next cycle. Every kept bit comes out exactly once, in order, with A before B for the same input bit.
- R9: When input bits are offered every cycle and `outReady` stays 1, `outValid` stays 1 in every cycle after the first accepted bit, until the stream is drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input bit offered |
| inReady | output | 1 | Encoder takes the offered bit this cycle |
| inBit | input | 1 | Data bit to encode |
| inSop | input | 1 | Marks the first bit of a packet |
| rateSel | input | 2 | Payload rate, sampled with the first bit |
| outValid | output | 1 | A coded bit is available |
| outReady | input | 1 | Sink takes the coded bit this cycle |
| outBit | output | 1 | Coded bit |

## Verification
Two events can fall in the same cycle. One is popping the last kept bit of one input bit. The other is loading the next input bit, which may cross a header-to-payload or packet boundary. The bench provokes this case in runs where both sides are always ready, and judges it by the gap-free output rule and the exact coded sequence. It provokes the other collision, a stall in the middle of a pattern, by dropping `outReady` at random for long stretches. In that case the held output must stay stable, and the resumed sequence must match a bench model that computes the code and the puncturing on its own.

// File: rtl/pce_pkg.sv
package pce_pkg;

  typedef enum logic [1:0] {
    RATE_HALF           = 2'd0,
    RATE_TWO_THIRDS     = 2'd1,
    RATE_THREE_QUARTERS = 2'd2,
    RATE_SPARE          = 2'd3
  } rate_e;

  // Strobes passed from the control to the datapath for each accepted input bit
  typedef struct packed {
    logic clearHist;
    logic keepA;
    logic keepB;
  } encCtl_t;

  // Number of input bits in one puncturing period
  function automatic logic [1:0] periodOf(rate_e r);
    case (r)
      RATE_TWO_THIRDS:     return 2'd2;
      RATE_THREE_QUARTERS: return 2'd3;
      default:             return 2'd1;
    endcase
  endfunction

  // Returns {keepA, keepB} for a payload bit at the given pattern position
  function automatic logic [1:0] keepMask(rate_e r, logic [1:0] ph);
    logic [1:0] m;
    m = 2'b11;
    case (r)
      RATE_TWO_THIRDS:     if (ph == 2'd1) m = 2'b10;
      RATE_THREE_QUARTERS: begin
        if (ph == 2'd1) m = 2'b10;
        else if (ph == 2'd2) m = 2'b01;
      end
      default:             m = 2'b11;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pce_ctrl.sv
module pce_ctrl
  import pce_pkg::*;
#(
  parameter int HDR_BITS = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       accept,
  input  logic       inSop,
  input  logic [1:0] rateSel,
  output encCtl_t    ctl
);

  localparam int CW = $clog2(HDR_BITS + 1);
  localparam logic [CW-1:0] HDR_LIM = CW'(HDR_BITS);

  logic [CW-1:0] hdrCnt;
  logic [1:0]    phase;
  rate_e         rateQ;
  logic          inHdr;
  logic [1:0]    mask;

  assign inHdr = inSop || (hdrCnt < HDR_LIM);
  assign mask  = inHdr ? 2'b11 : keepMask(rateQ, phase);

  assign ctl.clearHist = inSop;
  assign ctl.keepA     = mask[1];
  assign ctl.keepB     = mask[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrCnt <= '0;
      phase  <= 2'd0;
      rateQ  <= RATE_HALF;
    end else if (accept) begin
      if (inSop) begin
        rateQ  <= rate_e'(rateSel);
        hdrCnt <= CW'(1);
        phase  <= 2'd0;
      end else if (hdrCnt < HDR_LIM) begin
        hdrCnt <= hdrCnt + 1'b1;
      end else begin
        phase <= (phase == periodOf(rateQ) - 2'd1) ? 2'd0 : phase + 2'd1;
      end
    end
  end

  // R5 R6
  phase_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    phase < periodOf(rateQ));

  // R3
  header_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept && inSop |=> hdrCnt == CW'(1));

  // R7
  payload_phase_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept && !inSop && (hdrCnt == HDR_LIM - 1'b1) |=> phase == 2'd0);

endmodule

// File: rtl/pce_dp.sv
module pce_dp
  import pce_pkg::*;
#(
  parameter int             K   = 7,
  parameter logic [K-1:0]   G_A = 7'o133,
  parameter logic [K-1:0]   G_B = 7'o171
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inBit,
  input  encCtl_t ctl,
  input  logic    outReady,
  output logic    inReady,
  output logic    accept,
  output logic    outValid,
  output logic    outBit
);

  localparam int HW = K - 1;

  logic [HW-1:0] hist;
  logic [HW-1:0] histEff;
  logic [K-1:0]  win;
  logic          codeA, codeB;
  logic          hasA, hasB, bitA, bitB;
  logic          pop, lastOut;

  assign histEff = ctl.clearHist ? '0 : hist;
  assign win     = {inBit, histEff};
  assign codeA   = ^(win & G_A);
  assign codeB   = ^(win & G_B);

  assign outValid = hasA || hasB;
  assign outBit   = hasA ? bitA : bitB;
  assign pop      = outValid && outReady;
  assign lastOut  = hasA ^ hasB;
  assign inReady  = !outValid || (pop && lastOut);
  assign accept   = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist <= '0;
      hasA <= 1'b0;
      hasB <= 1'b0;
      bitA <= 1'b0;
      bitB <= 1'b0;
    end else if (accept) begin
      hist <= win[K-1:1];
      bitA <= codeA;
      bitB <= codeB;
      hasA <= ctl.keepA;
      hasB <= ctl.keepB;
    end else if (pop) begin
      if (hasA) hasA <= 1'b0;
      else      hasB <= 1'b0;
    end
  end

  // R8
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outBit));

  // R9
  accept_yields_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> outValid);

  // R5 R6
  accept_keeps_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> (ctl.keepA || ctl.keepB));

endmodule

// File: rtl/punct_conv_enc.sv
module punct_conv_enc
  import pce_pkg::*;
#(
  parameter int           HDR_BITS = 24,
  parameter int           K        = 7,
  parameter logic [K-1:0] G_A      = 7'o133,
  parameter logic [K-1:0] G_B      = 7'o171
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  input  logic       inBit,
  input  logic       inSop,
  input  logic [1:0] rateSel,
  output logic       outValid,
  input  logic       outReady,
  output logic       outBit
);

  encCtl_t ctl;
  logic    accept;

  pce_ctrl #(.HDR_BITS(HDR_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .accept(accept),
    .inSop(inSop), .rateSel(rateSel), .ctl(ctl)
  );

  pce_dp #(.K(K), .G_A(G_A), .G_B(G_B)) dp_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBit(inBit), .ctl(ctl),
    .outReady(outReady), .inReady(inReady), .accept(accept),
    .outValid(outValid), .outBit(outBit)
  );

endmodule

// File: tb/punct_conv_enc_tb.sv
module punct_conv_enc_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HDR = 24;

  logic clk = 1'b0;
  logic rstN, inValid, inBit, inSop, outReady;
  logic [1:0] rateSel;
  logic inReady, outValid, outBit;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit       inQ[$];
  bit       sopQ[$];
  bit [1:0] rateQ[$];
  bit       expQ[$];
  int       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  punct_conv_enc dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inBit(inBit), .inSop(inSop), .rateSel(rateSel),
    .outValid(outValid), .outReady(outReady), .outBit(outBit)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Bench model: computes the mother code (R2), the header rule (R3) and the puncturing (R4-R7)
  task automatic addPacket(int rate, int payloadBits);
    bit [5:0] h = '0;
    bit [6:0] w;
    bit u, a, b, kA, kB;
    int per, p;
    per = (rate == 1) ? 2 : (rate == 2) ? 3 : 1;
    for (int i = 0; i < HDR + payloadBits; i++) begin
      u = 1'($urandom_range(1, 0));
      inQ.push_back(u);
      sopQ.push_back(i == 0);
      // R4: rateSel is junk on every bit except the first
      rateQ.push_back(i == 0 ? 2'(rate) : 2'($urandom_range(3, 0)));
      w = {u, h};
      a = ^(w & 7'b1011011);
      b = ^(w & 7'b1111001);
      h = {u, h[5:1]};
      if (i < HDR) begin
        kA = 1; kB = 1;
      end else begin
        p = (i - HDR) % per;
        kA = 1; kB = 1;
        if (rate == 1 && p == 1) kB = 0;
        if (rate == 2 && p == 1) kB = 0;
        if (rate == 2 && p == 2) kA = 0;
      end
      if (kA) begin
        expQ.push_back(a);
        tagQ.push_back(i < HDR ? 3 : i == HDR ? 7 : rate == 1 ? 5 : rate == 2 ? 6 : rate == 3 ? 4 : 2);
      end
      if (kB) begin
        expQ.push_back(b);
        tagQ.push_back(i < HDR ? 3 : i == HDR ? 7 : rate == 1 ? 5 : rate == 2 ? 6 : rate == 3 ? 4 : 2);
      end
    end
  endtask

  task automatic runPhase(string name, int validPct, int readyPct);
    int inIdx = 0, outIdx = 0, cyc = 0, gaps = 0;
    bit started = 0, prevStall = 0, prevBit = 0, holdBad = 0, mism = 0;
    while ((outIdx < expQ.size() || inIdx < inQ.size()) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      inValid = (inIdx < inQ.size()) && ($urandom_range(99, 0) < validPct);
      if (inValid) begin
        inBit = inQ[inIdx]; inSop = sopQ[inIdx]; rateSel = rateQ[inIdx];
      end else begin
        inBit = 1'($urandom_range(1, 0)); inSop = 1'b0; rateSel = 2'($urandom_range(3, 0));
      end
      outReady = ($urandom_range(99, 0) < readyPct);
      #1;
      // R8: a stalled output holds
      if (prevStall && (!outValid || outBit != prevBit)) begin
        if (!holdBad) check(0, "R8", {name, " held output changed"}, int'(outBit), int'(prevBit));
        holdBad = 1;
      end
      // R9: no gaps while both sides always ready
      if (validPct == 100 && readyPct == 100 && started && outIdx < expQ.size() && !outValid) gaps++;
      if (outValid && outReady) begin
        if (outIdx >= expQ.size()) begin
          check(0, "R8", {name, " extra output bit"}, outIdx, expQ.size());
        end else begin
          if (outBit != expQ[outIdx]) mism = 1;
          check(outBit == expQ[outIdx], $sformatf("R%0d", tagQ[outIdx]),
                $sformatf("%s bit %0d", name, outIdx), int'(outBit), int'(expQ[outIdx]));
        end
        outIdx++;
      end
      if (inValid && inReady) begin
        inIdx++;
        started = 1;
      end
      prevStall = outValid && !outReady;
      prevBit = outBit;
    end
    @(negedge clk);
    inValid = 0; inSop = 0; outReady = 0;
    // R8: nothing lost, nothing duplicated
    check(outIdx == expQ.size(), "R8", {name, " output count"}, outIdx, expQ.size());
    check(inIdx == inQ.size(), "R8", {name, " input count"}, inIdx, inQ.size());
    if (validPct == 100 && readyPct == 100)
      check(gaps == 0, "R9", {name, " gap cycles"}, gaps, 0);
    if (!holdBad && readyPct < 100) check(1, "R8", {name, " hold"}, 0, 0);
    if (mism) $display("  (%s had mismatches)", name);
    inQ.delete(); sopQ.delete(); rateQ.delete(); expQ.delete(); tagQ.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R8 watchdog: actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 0; inValid = 0; inBit = 0; inSop = 0; rateSel = 0; outReady = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    #1;
    // R1
    check(outValid == 0, "R1", "outValid after reset", int'(outValid), 0);
    check(inReady == 1, "R1", "inReady after reset", int'(inReady), 1);

    // R2 R3 R9: rate 1/2 at full throughput
    addPacket(0, 40);
    runPhase("half_full", 100, 100);
    // R5 R9: rate 2/3, back-to-back packets
    addPacket(1, 33); addPacket(1, 17);
    runPhase("twothirds_full", 100, 100);
    // R6 R7: rate 3/4, odd payloads so the phase is mid-pattern at the packet end
    addPacket(2, 31); addPacket(2, 1); addPacket(2, 29);
    runPhase("threeq_full", 100, 100);
    // R4: spare code behaves as rate 1/2
    addPacket(3, 20);
    runPhase("spare_rate", 100, 100);
    // R7: header-only packet, then packets at different rates
    addPacket(2, 0); addPacket(1, 5); addPacket(2, 7); addPacket(0, 3);
    runPhase("phase_restart", 100, 100);
    // R8: heavy back-pressure mid-pattern
    addPacket(2, 50); addPacket(1, 50);
    runPhase("stall_heavy", 90, 20);
    // Random mix
    for (int k = 0; k < 30; k++) addPacket($urandom_range(3, 0), $urandom_range(60, 0));
    runPhase("random_mix", 70, 60);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule